// File: doc/BRIEF.md
# I/O Page System Register Decoder

This block sits on the processor's physical memory bus and answers every access whose address falls in the top 8 KB of the physical space, the I/O page. It rebases the page offset onto the 16-bit I/O window starting at octal 160000 and decodes it against a small set of internal system registers. These are the processor status word, the stack limit register, the CPU fault register, two memory-mapping control registers, a maintenance register, the console switch/display register, a two-word memory size register and a system identifier. Each register has its own rules for byte lanes, write masks and read-only or clear-on-write behaviour.

An access is accepted in the cycle `acc_valid` is high and the address is in the I/O page. The response comes one cycle later. `acc_done` pulses for one cycle and carries `acc_rdata`. `acc_err` pulses with it when the access must end in a bus-error trap through vector 4: a word access at an odd address, or an address or lane that no register claims. A new access can be accepted every cycle. A small state machine sequences the response. Its states are ST_IDLE (no response), ST_RD_ACK (read answered), ST_WR_ACK (write committed) and ST_FAULT (bus error). On every clock edge it moves to ST_FAULT, ST_WR_ACK or ST_RD_ACK according to the access accepted at that edge, and to ST_IDLE when no access is accepted.

Top module: `iopage_sysreg`

## Requirements
- R1: An access is answered only when `acc_addr` bits PA_W-1..13 are all ones. Its offset maps to rebased address 0160000 + `acc_addr[12:0]`. `acc_done` is high exactly in the cycle after acceptance. Outside the page there is no response and no register changes.
- R2: A word access (`acc_byte`=0) with `acc_addr[0]`=1 raises `acc_err`. It sets `map_ctl` bits 3:1 to 3'b111, the page number of the rebased address, and changes no other register.
- R3: An access to an address or byte lane that no register claims raises `acc_err` and changes no register. Odd-address byte accesses are claimed only by the status word, the stack limit and the map control register.
- R4: Status word at 0177776. A word write loads all bits except bit 4, the trace bit, which writes never change. A byte write at 0177776 loads bits 7:0, still keeping bit 4. A byte write at 0177777 loads bits 15:8. In both byte writes the data comes from `acc_wdata[7:0]`.
- R5: Stack limit at 0177774. A word write keeps only `acc_wdata[15:8]`, and bits 7:0 always read 0. A byte write at 0177775 loads the upper byte. A byte write at 0177774 has no effect.
- R6: CPU fault register at 0177766, 8 bits wide. Each cycle it ORs in `cpu_fault_set`. Any write clears it whatever the data, and set bits arriving in the same cycle survive the clear. A read returns its contents zero-extended.
- R7: Map control at 0177572 is fully readable and writable by word and by either byte (0177573 is the upper byte). Map extension at 0172516 takes word accesses only, holds 6 bits, and faults on a byte access.
- R8: Maintenance register at 0177750 always reads 1, meaning power is good. Writes to it are accepted and ignored.
- R9: Console at 0177570. A read returns `console_sw`. A word write loads `console_led`. A byte write loads only `console_led[7:0]`.
- R10: Memory size reads MEM_BYTES/64-1, low word at 0177760 and high word at 0177762. The system identifier at 0177764 reads SYS_ID. Writes to all three are accepted without error and have no effect.
- R11: Byte read data is zero-extended into `acc_rdata[7:0]`. A write response or error response returns `acc_rdata`=0. `acc_err` is high only together with `acc_done` and drops in the next cycle unless another access faults.
- R12: After reset `acc_done`, `acc_err`, `status_word`, `stack_limit`, `cpu_fault`, `map_ctl`, `map_ext` and `console_led` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = byte access (lane from acc_addr[0]), 0 = word |
| acc_addr | input | PA_W | Physical address |
| acc_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| acc_done | output | 1 | Response pulse, cycle after acceptance |
| acc_err | output | 1 | Bus-error trap pulse (vector 4) |
| acc_rdata | output | 16 | Read data of the response |
| console_sw | input | 16 | Console switch value |
| cpu_fault_set | input | 8 | Fault event bits to accumulate |
| console_led | output | 16 | Console display value |
| status_word | output | 16 | Processor status word |
| stack_limit | output | 16 | Stack limit value |
| cpu_fault | output | 8 | CPU fault register |
| map_ctl | output | 16 | Map control register |
| map_ext | output | MAPX_W | Map extension register |

## Verification
On every cycle the assertions check several invariants. The trace bit of the status word never changes. The low byte of the stack limit stays zero. Every accepted access gets a response one cycle later, and every response has a request behind it. An error response carries zero data and leaves the status word, stack limit and display untouched. An odd word access also sets the page field of the map control register, and the maintenance register reads 1. The bench scenarios cover the rest. They show the byte-lane merges, the clear-on-write of the fault register racing new fault bits, and the read-only size and identifier words. They also show that accesses outside the page get no answer, and that random mixes of lanes and addresses keep every register equal to an independently computed expectation.

// File: rtl/iopage_pkg.sv
package iopage_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_ACK,
        ST_WR_ACK,
        ST_FAULT
    } iop_state_t;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_STATUS,
        RID_LIMIT,
        RID_FAULT,
        RID_MAPC,
        RID_MAPX,
        RID_MAINT,
        RID_CONSOLE,
        RID_SIZE_LO,
        RID_SIZE_HI,
        RID_SYSID
    } reg_id_t;

    localparam int unsigned PAGE_BITS = 13;
    localparam logic [15:0] IO_WINDOW = 16'o160000;

    localparam logic [15:0] A_STATUS  = 16'o177776;
    localparam logic [15:0] A_LIMIT   = 16'o177774;
    localparam logic [15:0] A_FAULT   = 16'o177766;
    localparam logic [15:0] A_MAPC    = 16'o177572;
    localparam logic [15:0] A_MAPX    = 16'o172516;
    localparam logic [15:0] A_MAINT   = 16'o177750;
    localparam logic [15:0] A_CONSOLE = 16'o177570;
    localparam logic [15:0] A_SIZE_LO = 16'o177760;
    localparam logic [15:0] A_SIZE_HI = 16'o177762;
    localparam logic [15:0] A_SYSID   = 16'o177764;

    // Merge write data into an old value by lane; byte data comes from bits 7:0.
    function automatic logic [15:0] lane_merge(
        input logic [15:0] old_v,
        input logic [15:0] wd,
        input logic        is_byte,
        input logic        hi_lane
    );
        logic [15:0] r;
        if (!is_byte)     r = wd;
        else if (hi_lane) r = {wd[7:0], old_v[7:0]};
        else              r = {old_v[15:8], wd[7:0]};
        return r;
    endfunction

endpackage

// File: rtl/iopage_decode.sv
module iopage_decode
    import iopage_pkg::*;
#(
    parameter int unsigned PA_W = 22
) (
    input  logic [PA_W-1:0] addr,
    input  logic            is_byte,
    output logic            in_page,
    output reg_id_t         rid,
    output logic            hi_lane,
    output logic            odd_word,
    output logic            fault
);
    localparam int unsigned TOP_W = PA_W - PAGE_BITS;

    logic [15:0] rebased;
    logic [15:0] word_addr;
    logic        hi_ok;
    logic        claimed;

    assign in_page = &addr[PA_W-1 -: TOP_W];

    always_comb begin
        rebased   = IO_WINDOW | {3'b000, addr[PAGE_BITS-1:0]};
        word_addr = {rebased[15:1], 1'b0};
        hi_lane   = rebased[0];
        odd_word  = !is_byte && rebased[0];
        case (word_addr)
            A_STATUS:  rid = RID_STATUS;
            A_LIMIT:   rid = RID_LIMIT;
            A_FAULT:   rid = RID_FAULT;
            A_MAPC:    rid = RID_MAPC;
            A_MAPX:    rid = RID_MAPX;
            A_MAINT:   rid = RID_MAINT;
            A_CONSOLE: rid = RID_CONSOLE;
            A_SIZE_LO: rid = RID_SIZE_LO;
            A_SIZE_HI: rid = RID_SIZE_HI;
            A_SYSID:   rid = RID_SYSID;
            default:   rid = RID_NONE;
        endcase
        hi_ok   = (rid == RID_STATUS) || (rid == RID_LIMIT) || (rid == RID_MAPC);
        claimed = (rid != RID_NONE)
                  && (!is_byte || !hi_lane || hi_ok)
                  && (!is_byte || rid != RID_MAPX);
        fault   = odd_word || !claimed;
    end
endmodule

// File: rtl/iopage_regs.sv
module iopage_regs
    import iopage_pkg::*;
#(
    parameter int unsigned MAPX_W    = 6,
    parameter int unsigned FAULT_W   = 8,
    parameter int unsigned MEM_BYTES = 4190208,
    parameter logic [15:0] SYS_ID    = 16'o011064
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_wr,
    input  logic               set_page,
    input  reg_id_t            rid,
    input  logic               hi_lane,
    input  logic               is_byte,
    input  logic [15:0]        wdata,
    input  logic [15:0]        console_sw,
    input  logic [FAULT_W-1:0] fault_set,
    output logic [15:0]        rd_value,
    output logic [15:0]        status_word,
    output logic [15:0]        stack_limit,
    output logic [FAULT_W-1:0] cpu_fault,
    output logic [15:0]        map_ctl,
    output logic [MAPX_W-1:0]  map_ext,
    output logic [15:0]        console_led
);
    localparam logic [31:0] SIZE_VAL  = 32'(MEM_BYTES / 64 - 1);
    localparam int unsigned TRACE_BIT = 4;

    logic [7:0]  limit_hi;
    logic [15:0] status_next;
    logic [15:0] word_val;

    always_comb begin
        status_next = lane_merge(status_word, wdata, is_byte, hi_lane);
        status_next[TRACE_BIT] = status_word[TRACE_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_word <= '0;
            limit_hi    <= '0;
            map_ctl     <= '0;
            map_ext     <= '0;
            console_led <= '0;
        end else if (set_page) begin
            map_ctl[3:1] <= 3'b111;
        end else if (commit_wr) begin
            case (rid)
                RID_STATUS:  status_word <= status_next;
                RID_LIMIT: begin
                    if (!is_byte)     limit_hi <= wdata[15:8];
                    else if (hi_lane) limit_hi <= wdata[7:0];
                end
                RID_MAPC:    map_ctl     <= lane_merge(map_ctl, wdata, is_byte, hi_lane);
                RID_MAPX:    map_ext     <= wdata[MAPX_W-1:0];
                RID_CONSOLE: console_led <= lane_merge(console_led, wdata, is_byte, hi_lane);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_fault <= '0;
        end else begin
            cpu_fault <= ((commit_wr && rid == RID_FAULT) ? '0 : cpu_fault) | fault_set;
        end
    end

    assign stack_limit = {limit_hi, 8'h00};

    always_comb begin
        case (rid)
            RID_STATUS:  word_val = status_word;
            RID_LIMIT:   word_val = stack_limit;
            RID_FAULT:   word_val = 16'(cpu_fault);
            RID_MAPC:    word_val = map_ctl;
            RID_MAPX:    word_val = 16'(map_ext);
            RID_MAINT:   word_val = 16'd1;
            RID_CONSOLE: word_val = console_sw;
            RID_SIZE_LO: word_val = SIZE_VAL[15:0];
            RID_SIZE_HI: word_val = SIZE_VAL[31:16];
            RID_SYSID:   word_val = SYS_ID;
            default:     word_val = '0;
        endcase
        if (!is_byte)     rd_value = word_val;
        else if (hi_lane) rd_value = {8'h00, word_val[15:8]};
        else              rd_value = {8'h00, word_val[7:0]};
    end
endmodule

// File: rtl/iopage_ctrl.sv
module iopage_ctrl
    import iopage_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic        is_write,
    input  logic        fault,
    input  logic [15:0] rd_value,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata
);
    iop_state_t state_q;
    iop_state_t state_d;
    logic [15:0] rdata_q;

    always_comb begin
        if (!accept)       state_d = ST_IDLE;
        else if (fault)    state_d = ST_FAULT;
        else if (is_write) state_d = ST_WR_ACK;
        else               state_d = ST_RD_ACK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (accept && !fault && !is_write) ? rd_value : '0;
        end
    end

    always_comb begin
        rdata = rdata_q;
        unique case (state_q)
            ST_IDLE:   begin done = 1'b0; err = 1'b0; end
            ST_RD_ACK: begin done = 1'b1; err = 1'b0; end
            ST_WR_ACK: begin done = 1'b1; err = 1'b0; end
            ST_FAULT:  begin done = 1'b1; err = 1'b1; end
            default:   begin done = 1'b0; err = 1'b0; end
        endcase
    end
endmodule

// File: rtl/iopage_sysreg.sv
module iopage_sysreg
    import iopage_pkg::*;
#(
    parameter int unsigned PA_W      = 22,
    parameter int unsigned MAPX_W    = 6,
    parameter int unsigned MEM_BYTES = 4190208,
    parameter logic [15:0] SYS_ID    = 16'o011064
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_byte,
    input  logic [PA_W-1:0]   acc_addr,
    input  logic [15:0]       acc_wdata,
    output logic              acc_done,
    output logic              acc_err,
    output logic [15:0]       acc_rdata,
    input  logic [15:0]       console_sw,
    input  logic [7:0]        cpu_fault_set,
    output logic [15:0]       console_led,
    output logic [15:0]       status_word,
    output logic [15:0]       stack_limit,
    output logic [7:0]        cpu_fault,
    output logic [15:0]       map_ctl,
    output logic [MAPX_W-1:0] map_ext
);
    logic        in_page;
    reg_id_t     rid;
    logic        hi_lane;
    logic        odd_word;
    logic        fault;
    logic        accept;
    logic [15:0] rd_value;

    iopage_decode #(.PA_W(PA_W)) u_decode (
        .addr     (acc_addr),
        .is_byte  (acc_byte),
        .in_page  (in_page),
        .rid      (rid),
        .hi_lane  (hi_lane),
        .odd_word (odd_word),
        .fault    (fault)
    );

    assign accept = acc_valid && in_page;

    iopage_regs #(
        .MAPX_W    (MAPX_W),
        .FAULT_W   (8),
        .MEM_BYTES (MEM_BYTES),
        .SYS_ID    (SYS_ID)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_wr   (accept && acc_write && !fault),
        .set_page    (accept && odd_word),
        .rid         (rid),
        .hi_lane     (hi_lane),
        .is_byte     (acc_byte),
        .wdata       (acc_wdata),
        .console_sw  (console_sw),
        .fault_set   (cpu_fault_set),
        .rd_value    (rd_value),
        .status_word (status_word),
        .stack_limit (stack_limit),
        .cpu_fault   (cpu_fault),
        .map_ctl     (map_ctl),
        .map_ext     (map_ext),
        .console_led (console_led)
    );

    iopage_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .is_write (acc_write),
        .fault    (fault),
        .rd_value (rd_value),
        .done     (acc_done),
        .err      (acc_err),
        .rdata    (acc_rdata)
    );
endmodule

// File: rtl/iopage_sysreg_chk.sv
module iopage_sysreg_chk #(
    parameter int unsigned PA_W   = 22,
    parameter int unsigned MAPX_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              acc_byte,
    input logic [PA_W-1:0]   acc_addr,
    input logic              acc_done,
    input logic              acc_err,
    input logic [15:0]       acc_rdata,
    input logic [15:0]       console_led,
    input logic [15:0]       status_word,
    input logic [15:0]       stack_limit,
    input logic [15:0]       map_ctl
);
    logic in_pg;
    assign in_pg = &acc_addr[PA_W-1:13];

    a_r1_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_pg) |=> acc_done);

    a_r1_done_has_request: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> $past(acc_valid));

    a_r2_odd_word_page: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_pg && !acc_byte && acc_addr[0]) |=> (acc_err && map_ctl[3:1] == 3'b111));

    a_r3_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> ($stable(status_word) && $stable(stack_limit) && $stable(console_led)));

    a_r4_trace_bit_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(status_word[4]));

    a_r5_limit_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stack_limit[7:0] == 8'h00);

    a_r8_maint_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_pg && !acc_write && !acc_byte && acc_addr[12:0] == 13'o17750)
        |=> (acc_rdata == 16'd1 && !acc_err));

    a_r11_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_done && acc_rdata == 16'd0));
endmodule

bind iopage_sysreg iopage_sysreg_chk #(.PA_W(PA_W), .MAPX_W(MAPX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_byte    (acc_byte),
    .acc_addr    (acc_addr),
    .acc_done    (acc_done),
    .acc_err     (acc_err),
    .acc_rdata   (acc_rdata),
    .console_led (console_led),
    .status_word (status_word),
    .stack_limit (stack_limit),
    .map_ctl     (map_ctl)
);

// File: tb/tb_iopage_sysreg.sv
`timescale 1ns/1ps
module tb_iopage_sysreg;
    localparam int unsigned PA_W      = 22;
    localparam int unsigned MAPX_W    = 6;
    localparam int unsigned MEM_BYTES = 4190208;
    localparam logic [15:0] SYS_ID    = 16'o011064;
    localparam logic [31:0] EXP_SIZE  = 32'(MEM_BYTES / 64 - 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic              acc_byte = 1'b0;
    logic [PA_W-1:0]   acc_addr = '0;
    logic [15:0]       acc_wdata = '0;
    logic              acc_done;
    logic              acc_err;
    logic [15:0]       acc_rdata;
    logic [15:0]       console_sw = 16'h0000;
    logic [7:0]        cpu_fault_set = 8'h00;
    logic [15:0]       console_led;
    logic [15:0]       status_word;
    logic [15:0]       stack_limit;
    logic [7:0]        cpu_fault;
    logic [15:0]       map_ctl;
    logic [MAPX_W-1:0] map_ext;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model of the register contents
    logic [15:0] m_status = '0;
    logic [7:0]  m_lim    = '0;
    logic [7:0]  m_flt    = '0;
    logic [15:0] m_mapc   = '0;
    logic [5:0]  m_mapx   = '0;
    logic [15:0] m_led    = '0;

    always #10 clk = ~clk;

    iopage_sysreg #(
        .PA_W(PA_W), .MAPX_W(MAPX_W), .MEM_BYTES(MEM_BYTES), .SYS_ID(SYS_ID)
    ) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_byte(acc_byte), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_err(acc_err), .acc_rdata(acc_rdata),
        .console_sw(console_sw), .cpu_fault_set(cpu_fault_set),
        .console_led(console_led), .status_word(status_word),
        .stack_limit(stack_limit), .cpu_fault(cpu_fault), .map_ctl(map_ctl),
        .map_ext(map_ext)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic logic [15:0] off_of(input logic [15:0] a);
        return {3'b000, a[12:0]};
    endfunction

    task automatic check_state(input string tag);
        check({tag, " regs"}, {status_word, stack_limit, map_ctl, console_led},
              {m_status, m_lim, 8'h00, m_mapc, m_led});
        check({tag, " fault/ext"}, {48'h0, cpu_fault, 2'b00, map_ext}, {48'h0, m_flt, 2'b00, m_mapx});
    endtask

    // One access: drive, predict, let the edge pass, compare at the next falling edge.
    task automatic access(input string tag, input bit wr, input bit byt, input logic [12:0] off,
                          input logic [15:0] wd, input logic [7:0] fset, input bit outside);
        logic [15:0] a, wa, v, rd;
        bit hi, err, clr;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_byte = byt; acc_wdata = wd;
        acc_addr  = outside ? {9'h0FE, off} : {9'h1FF, off};
        cpu_fault_set = fset;
        a = 16'o160000 | {3'b000, off};
        hi = a[0]; wa = {a[15:1], 1'b0};
        err = 0; clr = 0; v = '0;
        if (!outside) begin
            if (!byt && hi) begin
                err = 1; m_mapc[3:1] = 3'b111;
            end else begin
                case (wa)
                    16'o177776: begin
                        v = m_status;
                        if (wr) begin
                            if (!byt)    m_status = {wd[15:5], m_status[4], wd[3:0]};
                            else if (hi) m_status[15:8] = wd[7:0];
                            else         m_status[7:0] = {wd[7:5], m_status[4], wd[3:0]};
                        end
                    end
                    16'o177774: begin
                        v = {m_lim, 8'h00};
                        if (wr) begin
                            if (!byt)    m_lim = wd[15:8];
                            else if (hi) m_lim = wd[7:0];
                        end
                    end
                    16'o177572: begin
                        v = m_mapc;
                        if (wr) begin
                            if (!byt)    m_mapc = wd;
                            else if (hi) m_mapc[15:8] = wd[7:0];
                            else         m_mapc[7:0] = wd[7:0];
                        end
                    end
                    16'o177766: if (byt && hi) err = 1; else begin v = {8'h00, m_flt}; clr = wr; end
                    16'o172516: if (byt) err = 1; else begin v = {10'h0, m_mapx}; if (wr) m_mapx = wd[5:0]; end
                    16'o177750: if (byt && hi) err = 1; else v = 16'd1;
                    16'o177570: if (byt && hi) err = 1; else begin
                        v = console_sw;
                        if (wr) begin if (!byt) m_led = wd; else m_led[7:0] = wd[7:0]; end
                    end
                    16'o177760: if (byt && hi) err = 1; else v = EXP_SIZE[15:0];
                    16'o177762: if (byt && hi) err = 1; else v = EXP_SIZE[31:16];
                    16'o177764: if (byt && hi) err = 1; else v = SYS_ID;
                    default: err = 1;
                endcase
            end
        end
        rd = (err || wr) ? 16'h0 : (byt ? {8'h00, (hi ? v[15:8] : v[7:0])} : v);
        m_flt = (clr ? 8'h00 : m_flt) | fset;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; cpu_fault_set = 8'h00;
        if (outside) check({tag, " resp"}, {47'h0, acc_done, acc_err, acc_rdata}, 64'h0);
        else         check({tag, " resp"}, {47'h0, acc_done, acc_err, acc_rdata}, {47'h0, 1'b1, err, rd});
        check_state(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        console_sw = 16'hA5C3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 reset resp", {62'h0, acc_done, acc_err}, 64'h0);
        check_state("R12 reset");

        // R4 trace bit and lanes
        access("R4 word write keeps trace", 1, 0, off_of(16'o177776), 16'hFFFF, 8'h00, 0);
        access("R4 byte low write", 1, 1, off_of(16'o177776), 16'h0000, 8'h00, 0);
        access("R4 byte high write", 1, 1, off_of(16'o177777), 16'h005A, 8'h00, 0);
        access("R4 word read", 0, 0, off_of(16'o177776), 16'h0, 8'h00, 0);
        // R5 stack limit
        access("R5 word write", 1, 0, off_of(16'o177774), 16'h1234, 8'h00, 0);
        access("R5 low byte ignored", 1, 1, off_of(16'o177774), 16'h00FF, 8'h00, 0);
        access("R5 high byte write", 1, 1, off_of(16'o177775), 16'h0077, 8'h00, 0);
        access("R5 high byte read", 0, 1, off_of(16'o177775), 16'h0, 8'h00, 0);
        // R6 fault register
        access("R6 set via events", 0, 0, off_of(16'o177750), 16'h0, 8'h81, 0);
        access("R6 word read", 0, 0, off_of(16'o177766), 16'h0, 8'h00, 0);
        access("R6 byte write clears", 1, 1, off_of(16'o177766), 16'h00FF, 8'h00, 0);
        access("R6 clear with same-cycle set", 1, 0, off_of(16'o177766), 16'h0000, 8'h10, 0);
        // R7 mapping registers
        access("R7 map ctl word", 1, 0, off_of(16'o177572), 16'hC0F0, 8'h00, 0);
        access("R7 map ctl high byte", 1, 1, off_of(16'o177573), 16'h0012, 8'h00, 0);
        access("R7 map ext word", 1, 0, off_of(16'o172516), 16'hFFFF, 8'h00, 0);
        access("R7 map ext byte faults", 1, 1, off_of(16'o172516), 16'h0000, 8'h00, 0);
        // R8 maintenance
        access("R8 maint read", 0, 0, off_of(16'o177750), 16'h0, 8'h00, 0);
        access("R8 maint write ignored", 1, 0, off_of(16'o177750), 16'h1234, 8'h00, 0);
        // R9 console
        access("R9 switch read", 0, 0, off_of(16'o177570), 16'h0, 8'h00, 0);
        access("R9 led word", 1, 0, off_of(16'o177570), 16'hBEEF, 8'h00, 0);
        access("R9 led byte", 1, 1, off_of(16'o177570), 16'h0011, 8'h00, 0);
        // R10 size and identifier
        access("R10 size low", 0, 0, off_of(16'o177760), 16'h0, 8'h00, 0);
        access("R10 size high", 0, 0, off_of(16'o177762), 16'h0, 8'h00, 0);
        access("R10 sysid", 0, 0, off_of(16'o177764), 16'h0, 8'h00, 0);
        access("R10 sysid write ignored", 1, 0, off_of(16'o177764), 16'hFFFF, 8'h00, 0);
        access("R10 size write ignored", 1, 0, off_of(16'o177760), 16'h0000, 8'h00, 0);
        // R2 odd word, R3 unmapped
        access("R2 odd word write", 1, 0, off_of(16'o177777), 16'hFFFF, 8'h00, 0);
        check("R2 map ctl page field", {61'h0, map_ctl[3:1]}, 64'h7);
        access("R3 unmapped read", 0, 0, off_of(16'o170000), 16'h0, 8'h00, 0);
        access("R3 odd byte unclaimed", 1, 1, off_of(16'o177571), 16'h00FF, 8'h00, 0);
        // R11 error is a one-cycle pulse
        @(negedge clk);
        check("R11 err drops", {62'h0, acc_done, acc_err}, 64'h0);
        // R11 byte read zero extension
        access("R11 byte read high status", 0, 1, off_of(16'o177777), 16'h0, 8'h00, 0);
        // R1 outside page
        access("R1 outside page", 1, 0, off_of(16'o177776), 16'h0000, 8'h00, 1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] pick;
            logic [12:0] off;
            int k;
            k = int'($urandom % 14);
            case (k)
                0: pick = 16'o177776;  1: pick = 16'o177774;  2: pick = 16'o177766;
                3: pick = 16'o177572;  4: pick = 16'o172516;  5: pick = 16'o177750;
                6: pick = 16'o177570;  7: pick = 16'o177760;  8: pick = 16'o177762;
                9: pick = 16'o177764;  default: pick = 16'($urandom);
            endcase
            off = pick[12:0];
            if ($urandom % 10 < 3) off[0] = ~off[0];
            console_sw = 16'($urandom);
            access("random R1 to R11", ($urandom % 2) == 1, ($urandom % 2) == 1, off, 16'($urandom),
                   ($urandom % 8 == 0) ? 8'($urandom) : 8'h00, ($urandom % 16) == 0);
        end
        summary();
    end
endmodule